// File: doc/BRIEF.md
# Panel Serial Configuration Sequencer

This block configures a small display panel through a write-only three-wire serial port made of an active-low frame enable, a serial clock and a data line. Two command lists are fixed in the block: a five-write list that brings the panel up and a one-write list that turns it off. The host raises `start` for one cycle with `sel_on` choosing the list. The block then sends every write of that list in order. It holds `busy` high while it works and pulses `done` once at the end.

Each write is a 16-bit frame: an 8-bit register address followed by an 8-bit data byte, most significant bit first. The serial clock idles high and comes from the system clock. Each of its low and high phases lasts `DIV` system clocks. Data changes only while the clock is low, so the panel can sample it on the rising edge. Between two writes the enable returns high for at least one full serial-clock period.

Top module: `panel_cfg_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, cfg_en_n is 1, cfg_sclk is 1, cfg_sdat is 0, busy is 0 and done is 0.
- R2: Each write is one frame of exactly 16 rising clock edges while cfg_en_n is 0. Frame bits 15:8 hold the register address and bits 7:0 hold the data byte, sent most significant bit first. cfg_en_n returns to 1 after the 16th bit.
- R3: Whenever cfg_en_n is 1, cfg_sclk is 1 and cfg_sdat is 0. This includes the moment cfg_en_n falls to begin a frame.
- R4: cfg_sdat changes only while cfg_sclk is 0 or cfg_en_n is 1. While cfg_en_n is 0, every low phase and every high phase of cfg_sclk that is closed by an edge lasts exactly DIV system clocks.
- R5: With sel_on = 1 the block sends five frames in this order: (0x05,0x1E), (0x05,0x5E), (0x07,0x8D), (0x13,0x01), (0x05,0x5F).
- R6: With sel_on = 0 the block sends exactly one frame: (0x05,0x5E).
- R7: Between consecutive frames of one sequence, cfg_en_n stays 1 for at least 2*DIV system clocks.
- R8: done is high for exactly one cycle, in the first cycle after a sequence in which busy reads 0. busy falls only together with done.
- R9: A start pulse while busy is 1 is ignored. The running list continues unchanged, no extra frame is sent and only one done pulse occurs.
- R10: A start sampled while busy is 0 makes busy read 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run a list |
| sel_on | input | 1 | List select: 1 = bring-up list, 0 = shut-down list |
| busy | output | 1 | High while a list is being sent |
| done | output | 1 | One-cycle pulse when the list is finished |
| cfg_en_n | output | 1 | Serial frame enable, active low |
| cfg_sclk | output | 1 | Serial clock, idle high |
| cfg_sdat | output | 1 | Serial data, valid at rising cfg_sclk |

## Verification
A receiver model in the bench rebuilds every frame from the rising clock edges while the enable is low. Its checks catch a shifter that sends the data byte first or the least significant bit first, which would garble every captured pair, and a bit counter that ends at 15 or 17, which the frame-length check rejects. A monitor measures each clock phase and each idle gap. It catches a divider that is off by one and a sequencer that reissues the next frame without the inter-frame gap. Other scenarios pulse start in the middle of a bring-up run and run the two lists back to back. A design that restarts or relatches its select on such a pulse would send the wrong list or raise done twice.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int ON_LEN  = 5;
    localparam int OFF_LEN = 1;
    localparam int IDX_W   = $clog2(ON_LEN);

    typedef struct packed {
        logic [ADDR_W-1:0] reg_addr;
        logic [DATA_W-1:0] value;
    } cfg_word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_GAP
    } tx_phase_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } sq_state_t;

    // Command lists: bring-up (on = 1) and shut-down (on = 0)
    function automatic cfg_word_t cmd_at(input logic on, input logic [IDX_W-1:0] idx);
        cfg_word_t w;
        w = '0;
        if (on) begin
            case (idx)
                IDX_W'(0): w = cfg_word_t'{reg_addr: 8'h05, value: 8'h1E};
                IDX_W'(1): w = cfg_word_t'{reg_addr: 8'h05, value: 8'h5E};
                IDX_W'(2): w = cfg_word_t'{reg_addr: 8'h07, value: 8'h8D};
                IDX_W'(3): w = cfg_word_t'{reg_addr: 8'h13, value: 8'h01};
                IDX_W'(4): w = cfg_word_t'{reg_addr: 8'h05, value: 8'h5F};
                default:   w = '0;
            endcase
        end else begin
            w = cfg_word_t'{reg_addr: 8'h05, value: 8'h5E};
        end
        return w;
    endfunction

    function automatic logic [IDX_W-1:0] last_idx(input logic on);
        return on ? IDX_W'(ON_LEN - 1) : IDX_W'(OFF_LEN - 1);
    endfunction

endpackage

// File: rtl/panel_cmd_table.sv
module panel_cmd_table
    import panel_cfg_pkg::*;
(
    input  logic               sel_on,
    input  logic [IDX_W-1:0]   idx,
    output logic [FRAME_W-1:0] frame,
    output logic               is_last
);

    cfg_word_t word;

    always_comb begin
        word    = cmd_at(sel_on, idx);
        frame   = word;
        is_last = (idx == last_idx(sel_on));
    end

endmodule

// File: rtl/panel_serial_tx.sv
module panel_serial_tx
    import panel_cfg_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [FRAME_W-1:0] frame,
    output logic               en_n,
    output logic               sclk,
    output logic               sdat,
    output logic               fin
);

    localparam int CW = (2 * DIV > 1) ? $clog2(2 * DIV) : 1;
    localparam int BW = $clog2(FRAME_W);
    localparam logic [CW-1:0] HALF_END = CW'(DIV - 1);
    localparam logic [CW-1:0] GAP_END  = CW'(2 * DIV - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    tx_phase_t          phase;
    logic [CW-1:0]      cnt;
    logic [BW-1:0]      bit_no;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            bit_no <= '0;
            shreg  <= '0;
            en_n   <= 1'b1;
            sclk   <= 1'b1;
            sdat   <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase  <= PH_LEAD;
                        en_n   <= 1'b0;
                        cnt    <= '0;
                        bit_no <= '0;
                        shreg  <= frame;
                    end
                end
                PH_LEAD: begin
                    if (cnt == HALF_END) begin
                        cnt   <= '0;
                        phase <= PH_LOW;
                        sclk  <= 1'b0;
                        sdat  <= shreg[FRAME_W-1];
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt == HALF_END) begin
                        cnt   <= '0;
                        phase <= PH_HIGH;
                        sclk  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == HALF_END) begin
                        cnt <= '0;
                        if (bit_no == LAST_BIT) begin
                            phase <= PH_GAP;
                            en_n  <= 1'b1;
                            sdat  <= 1'b0;
                        end else begin
                            bit_no <= bit_no + 1'b1;
                            phase  <= PH_LOW;
                            sclk   <= 1'b0;
                            sdat   <= shreg[FRAME_W-1];
                            shreg  <= {shreg[FRAME_W-2:0], 1'b0};
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt == GAP_END) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                        fin   <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3
    idle_levels_chk: assert property (@(posedge clk) disable iff (rst)
        en_n |-> (sclk && !sdat));

    // R4
    data_setup_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdat) |-> (!sclk || en_n));

    // R4
    clock_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> !en_n);

    // R2
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> en_n);

endmodule

// File: rtl/panel_cfg_sequencer.sv
module panel_cfg_sequencer
    import panel_cfg_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic sel_on,
    output logic busy,
    output logic done,
    output logic cfg_en_n,
    output logic cfg_sclk,
    output logic cfg_sdat
);

    sq_state_t          state;
    logic               sel_q;
    logic [IDX_W-1:0]   idx;
    logic [FRAME_W-1:0] cur_frame;
    logic               cur_last;
    logic               tx_go;
    logic               tx_fin;

    panel_cmd_table u_table (
        .sel_on  (sel_q),
        .idx     (idx),
        .frame   (cur_frame),
        .is_last (cur_last)
    );

    panel_serial_tx #(.DIV(DIV)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .go    (tx_go),
        .frame (cur_frame),
        .en_n  (cfg_en_n),
        .sclk  (cfg_sclk),
        .sdat  (cfg_sdat),
        .fin   (tx_fin)
    );

    assign tx_go = (state == SQ_ISSUE);
    assign busy  = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            sel_q <= 1'b0;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        sel_q <= sel_on;
                        idx   <= '0;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (tx_fin) begin
                        if (cur_last) begin
                            state <= SQ_IDLE;
                            idx   <= '0;
                            done  <= 1'b1;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_ISSUE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(sel_q));

    // R10
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3
    enable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cfg_en_n);

endmodule

// File: tb/panel_cfg_sequencer_test.sv
`timescale 1ns/1ps
module panel_cfg_sequencer_test;

    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sel_on = 1'b0;
    logic busy, done, cfg_en_n, cfg_sclk, cfg_sdat;

    always #2.5 clk = ~clk;

    panel_cfg_sequencer #(.DIV(DIV)) uut (
        .clk(clk), .rst(rst), .start(start), .sel_on(sel_on),
        .busy(busy), .done(done),
        .cfg_en_n(cfg_en_n), .cfg_sclk(cfg_sclk), .cfg_sdat(cfg_sdat)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected lists
    logic [15:0] exp_on [0:4] = '{16'h051E, 16'h055E, 16'h078D, 16'h1301, 16'h055F};
    logic [15:0] exp_off [0:0] = '{16'h055E};

    // Panel receiver model
    logic [15:0] cap [0:15];
    int cap_n = 0;
    logic [15:0] rx_sh = '0;
    int rx_bits = 0;
    int len_bad = 0;
    int pre_bad = 0;

    always @(posedge cfg_sclk) begin
        if (rst === 1'b0 && cfg_en_n === 1'b0) begin
            rx_sh = {rx_sh[14:0], cfg_sdat};
            rx_bits++;
        end
    end

    always @(negedge cfg_en_n) begin
        rx_bits = 0;
        if (!(cfg_sclk === 1'b1 && cfg_sdat === 1'b0)) pre_bad++;
    end

    always @(posedge cfg_en_n) begin
        if (rst === 1'b0) begin
            if (rx_bits != 16) len_bad++;
            if (cap_n < 16) cap[cap_n] = rx_sh;
            cap_n++;
        end
    end

    // Line timing monitor
    int run = 0;
    logic prev_sclk = 1'b1;
    logic prev_sdat = 1'b0;
    int phase_bad = 0;
    int hold_bad = 0;
    int idle_bad = 0;
    int gap_run = 0;
    int gap_min = 1000000;
    int frames_in_seq = 0;

    always @(negedge clk) begin
        if (rst === 1'b0) begin
            if (cfg_en_n) begin
                if (!(cfg_sclk === 1'b1 && cfg_sdat === 1'b0)) idle_bad++;
                run = 0;
                gap_run++;
            end else begin
                if (gap_run > 0 && frames_in_seq > 0 && gap_run < gap_min) gap_min = gap_run;
                if (gap_run > 0) frames_in_seq++;
                gap_run = 0;
                if (cfg_sclk !== prev_sclk) begin
                    if (run != DIV) phase_bad++;
                    run = 1;
                end else begin
                    run++;
                end
                if (cfg_sclk && prev_sclk && cfg_sdat !== prev_sdat) hold_bad++;
            end
            prev_sclk = cfg_sclk;
            prev_sdat = cfg_sdat;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic clear_monitor();
        cap_n = 0;
        len_bad = 0; pre_bad = 0; phase_bad = 0; hold_bad = 0; idle_bad = 0;
        gap_min = 1000000; frames_in_seq = 0;
    endtask

    // Start a list and wait for done; optional disturbing start mid-run
    task automatic run_list(input logic on, input bit disturb, output int done_seen);
        int waited;
        int busy_gap;
        @(negedge clk);
        chk(busy == 1'b0, "R10 idle before start", busy, 0);
        start = 1'b1; sel_on = on;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        done_seen = 0; waited = 0; busy_gap = 0;
        while (done_seen == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (disturb && waited == 50) begin
                start = 1'b1; sel_on = ~on;
            end else if (disturb && waited == 51) begin
                start = 1'b0;
            end
            if (done) done_seen++;
            else if (!busy) busy_gap++;
        end
        chk(busy_gap == 0, "R8 busy held until done", busy_gap, 0);
        chk(done_seen == 1 && busy == 1'b0, "R8 done with busy low", {busy, 8'(done_seen)}, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        repeat (4 * DIV) begin
            @(negedge clk);
            if (done) done_seen++;
        end
    endtask

    task automatic check_lines(input int n);
        chk(len_bad == 0, "R2 sixteen bits per frame", len_bad, 0);
        chk(pre_bad == 0 && idle_bad == 0, "R3 idle levels", pre_bad + idle_bad, 0);
        chk(phase_bad == 0, "R4 phase width DIV", phase_bad, 0);
        chk(hold_bad == 0, "R4 data stable while clock high", hold_bad, 0);
        if (n > 1)
            chk(gap_min >= 2 * DIV, "R7 gap between frames", gap_min, 2 * DIV);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cfg_en_n == 1 && cfg_sclk == 1 && cfg_sdat == 0, "R1 lines in reset",
            {cfg_en_n, cfg_sclk, cfg_sdat}, 3'b110);
        chk(busy == 0 && done == 0, "R1 flags in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cfg_en_n == 1 && cfg_sclk == 1 && cfg_sdat == 0 && busy == 0 && done == 0,
            "R1 after reset", {cfg_en_n, cfg_sclk, cfg_sdat, busy, done}, 5'b11000);
    endtask

    task automatic t_on();
        int d;
        clear_monitor();
        run_list(1'b1, 1'b0, d);
        chk(cap_n == 5, "R5 frame count", cap_n, 5);
        for (int i = 0; i < 5; i++)
            chk(cap[i] == exp_on[i], "R5 R2 frame content", cap[i], exp_on[i]);
        check_lines(5);
    endtask

    task automatic t_off();
        int d;
        clear_monitor();
        run_list(1'b0, 1'b0, d);
        chk(cap_n == 1, "R6 frame count", cap_n, 1);
        chk(cap[0] == exp_off[0], "R6 frame content", cap[0], exp_off[0]);
        check_lines(1);
    endtask

    task automatic t_busy_ignore();
        int d;
        clear_monitor();
        run_list(1'b1, 1'b1, d);
        chk(d == 1, "R9 single done", d, 1);
        chk(cap_n == 5, "R9 no extra frame", cap_n, 5);
        for (int i = 0; i < 5; i++)
            chk(cap[i] == exp_on[i], "R9 list unchanged", cap[i], exp_on[i]);
        check_lines(5);
    endtask

    task automatic t_back_to_back();
        int d;
        clear_monitor();
        run_list(1'b0, 1'b0, d);
        run_list(1'b1, 1'b0, d);
        chk(cap_n == 6, "R5 R6 back to back count", cap_n, 6);
        chk(cap[0] == exp_off[0], "R6 first of pair", cap[0], exp_off[0]);
        chk(cap[5] == exp_on[4], "R5 last of pair", cap[5], exp_on[4]);
    endtask

    initial begin
        t_reset();
        t_on();
        t_off();
        t_busy_ignore();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule